// File: doc/BRIEF.md
# SPI Slave Command Framer

This block is the serial front end of a device register port. It acts as an SPI slave in mode 0 and oversamples the pins with the system clock. Every transaction opens with a 16-bit command word. The top bit of that word chooses read or write, three bits choose one of seven internal targets, and the low twelve bits give the number of 16-bit data words that follow. The framer moves those words between the serial line and a simple parallel target bus. Each word on that bus is marked by a single-cycle read or write strobe, and the target code is shown on a select bus.

The order of bits and bytes on the line comes from a word-order setting. Words can go out as plain 16-bit words, as 32-bit words with the upper half first, or byte by byte with the low byte first. Accesses to the configuration target always use the plain 16-bit order.

An optional chip-select framing check ties each transaction to the chip-select window. When it is on, chip select rising in the middle of a command or transfer raises a sticky error flag, and the parser drops back to waiting for a new command. The link can then resynchronise without a reset. When framing is off, chip select high only pauses the transfer.

Top module: `spi_cmd_framer`

## Requirements
- R1: Command word decoding, with the first bit received being bit 15. Bit 15 is 1 for read and 0 for write. Bits 14..12 are the target code and bits 11..0 are the word count. `tgt_sel` carries the target code during every strobe of that command.
- R2: A write command with count N produces one `tgt_wr` pulse per received word, in line order, with the word on `tgt_wdata`. Each pulse comes after the last bit of its line unit.
- R3: A read command with count N produces one `tgt_rd` pulse per word, sampling `tgt_rdata` in the pulse cycle. The word is returned on MISO starting at the first data bit.
- R4: Word order 00: every word travels as 16 bits, most significant bit first.
- R5: Word order 10: every word travels low byte first, each byte most significant bit first.
- R6: Word order 01: words are paired into 32-bit units sent most significant bit first. The second word of a pair is the upper half and goes on the line first, while bus strobes stay lower word first. A trailing odd word travels as in order 00.
- R7: Target code 000 (config) always uses order 00, whatever the word-order input says. Order code 11 also behaves as 00.
- R8: A read of target 001 (control) returns zero for every word after the first, with no `tgt_rd` strobe for those words.
- R9: Target code 111 produces no strobes. Reads from it return zeros.
- R10: A count of zero completes at the end of the command word. A new command may follow at once while chip select stays low.
- R11: With `cfg_frame_en` high, chip select rising during a partial command or before the count is exhausted sets `err_frame`. The unfinished line unit is discarded, and the next bits after chip select falls are decoded as a command. A complete transaction never sets the flag.
- R12: With `cfg_frame_en` low, chip select high only pauses shifting. The transfer resumes when it falls again, and `err_frame` does not change.
- R13: `err_frame` is low after reset and stays set until an `err_clr` pulse. If a set and a clear arrive in the same cycle, the set wins.
- R14: MISO changes only after SCLK falling edges or chip select rising, and holds while SCLK is high. SCLK high and low phases must each last at least 6 `clk` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Host-to-device serial data |
| spi_miso | output | 1 | Device-to-host serial data |
| cfg_word_mode | input | 2 | Line word order: 00 16-bit, 01 32-bit, 10 bytewise |
| cfg_frame_en | input | 1 | Enables chip-select framing checks |
| err_clr | input | 1 | Single-cycle pulse that clears the framing error flag |
| err_frame | output | 1 | Sticky chip-select framing error |
| tgt_sel | output | 3 | Target code of the current command |
| tgt_wr | output | 1 | Write strobe, one cycle per word |
| tgt_rd | output | 1 | Read strobe, one cycle per word |
| tgt_wdata | output | 16 | Write data word |
| tgt_rdata | input | 16 | Read data word, valid in the `tgt_rd` cycle |

## Verification
A wrong bit or word counter shifts every later word by some bits, so it shows up in the first transfer after the error. The bench then sees garbled `tgt_wdata` values or MISO streams, and the strobe count for that command comes out wrong. If the latched word order or target code is wrong, one whole command is swapped by byte or by half, and the error is visible within a single 32-bit unit. If framing recovery is broken, `err_frame` stays low a few cycles after chip select rises, or the command after the abort is decoded out of step, which the next strobe exposes.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int WORD_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int UNIT_W   = 2 * WORD_W;
    localparam int CMD_W    = 16;
    localparam int TGT_W    = 3;
    localparam int LEN_W    = CMD_W - 1 - TGT_W;
    localparam int BITCNT_W = $clog2(UNIT_W);

    typedef enum logic [TGT_W-1:0] {
        TGT_CFG   = 3'd0,
        TGT_CTRL  = 3'd1,
        TGT_QUEUE = 3'd2,
        TGT_AHB   = 3'd3,
        TGT_MADDR = 3'd4,
        TGT_SRAM  = 3'd5,
        TGT_GP    = 3'd6,
        TGT_NONE  = 3'd7
    } tgt_e;

    typedef enum logic [1:0] {
        ORD_HALF = 2'b00,
        ORD_FULL = 2'b01,
        ORD_BYTE = 2'b10,
        ORD_RSVD = 2'b11
    } ord_e;

    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e                phase;
        logic [BITCNT_W-1:0]   bit_cnt;
        logic [UNIT_W-1:0]     rx_sh;
        logic                  is_rd;
        logic [TGT_W-1:0]      tgt;
        ord_e                  ord;
        logic                  unit32;
        logic [LEN_W-1:0]      left;
        logic [LEN_W-1:0]      idx;
        logic [UNIT_W-1:0]     tx_sh;
        logic                  miso;
        logic [1:0]            bus_cnt;
        logic                  bus_rd;
        logic                  bus_unit32;
        logic [LEN_W-1:0]      bus_idx;
        logic [WORD_W-1:0]     word0;
        logic [WORD_W-1:0]     word1;
        logic                  err;
    } fr_st_t;

    function automatic logic [WORD_W-1:0] byte_swap(input logic [WORD_W-1:0] w);
        return {w[BYTE_W-1:0], w[WORD_W-1:BYTE_W]};
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_rise,
    output logic cs_low,
    output logic mosi_o
);

    localparam logic [2:0] PIN_RST = 3'b010;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [2:0] q;
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= PIN_RST;
                else        q <= {sclk_i, cs_n_i, mosi_i};
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= PIN_RST;
                else        q <= g_stage[g-1].q;
            end
        end
    end

    logic [2:0] synced;
    logic [1:0] prev_q;

    assign synced = g_stage[STAGES-1].q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 2'b01;
        else        prev_q <= synced[2:1];
    end

    assign sclk_rise = synced[2] & ~prev_q[1];
    assign sclk_fall = ~synced[2] & prev_q[1];
    assign cs_rise   = synced[1] & ~prev_q[0];
    assign cs_low    = ~synced[1];
    assign mosi_o    = synced[0];

endmodule

// File: rtl/spi_unit_order.sv
module spi_unit_order
    import spi_cmd_pkg::*;
(
    input  ord_e              ord,
    input  logic              rx_unit32,
    input  logic [UNIT_W-1:0] rx_line,
    output logic [WORD_W-1:0] rx_lo,
    output logic [WORD_W-1:0] rx_hi,
    input  logic              tx_unit32,
    input  logic [WORD_W-1:0] tx_lo,
    input  logic [WORD_W-1:0] tx_hi,
    output logic [UNIT_W-1:0] tx_line
);

    logic swap;
    assign swap = (ord == ORD_BYTE);

    always_comb begin
        if (rx_unit32) begin
            rx_hi = rx_line[UNIT_W-1:WORD_W];
            rx_lo = rx_line[WORD_W-1:0];
        end else begin
            rx_hi = '0;
            rx_lo = swap ? byte_swap(rx_line[WORD_W-1:0]) : rx_line[WORD_W-1:0];
        end
    end

    always_comb begin
        if (tx_unit32) tx_line = {tx_hi, tx_lo};
        else           tx_line = {(swap ? byte_swap(tx_lo) : tx_lo), {WORD_W{1'b0}}};
    end

endmodule

// File: rtl/spi_cmd_framer.sv
module spi_cmd_framer
    import spi_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [1:0]        cfg_word_mode,
    input  logic              cfg_frame_en,
    input  logic              err_clr,
    output logic              err_frame,
    output logic [TGT_W-1:0]  tgt_sel,
    output logic              tgt_wr,
    output logic              tgt_rd,
    output logic [WORD_W-1:0] tgt_wdata,
    input  logic [WORD_W-1:0] tgt_rdata
);

    localparam logic [BITCNT_W-1:0] LAST16 = BITCNT_W'(WORD_W - 1);
    localparam logic [BITCNT_W-1:0] LAST32 = BITCNT_W'(UNIT_W - 1);
    localparam logic [BITCNT_W-1:0] LASTCMD = BITCNT_W'(CMD_W - 1);

    fr_st_t st_q, st_d;

    logic sclk_rise, sclk_fall, cs_rise, cs_low, mosi_s;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (spi_sclk),
        .cs_n_i    (spi_cs_n),
        .mosi_i    (spi_mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_rise   (cs_rise),
        .cs_low    (cs_low),
        .mosi_o    (mosi_s)
    );

    logic [UNIT_W-1:0] rx_next;
    logic [WORD_W-1:0] rx_lo, rx_hi;
    logic [UNIT_W-1:0] tx_line;
    logic              bus_hi;
    logic [LEN_W-1:0]  cur_idx;
    logic              strobe_ok;
    logic [WORD_W-1:0] rd_val;
    logic [WORD_W-1:0] tx_lo_in;

    assign rx_next   = {st_q.rx_sh[UNIT_W-2:0], mosi_s};
    assign bus_hi    = (st_q.bus_cnt == 2'd1) && st_q.bus_unit32;
    assign cur_idx   = st_q.bus_idx + {{(LEN_W-1){1'b0}}, bus_hi};
    assign strobe_ok = (st_q.tgt != TGT_NONE) &&
                       !(st_q.bus_rd && (st_q.tgt == TGT_CTRL) && (cur_idx != '0));
    assign rd_val    = strobe_ok ? tgt_rdata : '0;
    assign tx_lo_in  = st_q.bus_unit32 ? st_q.word0 : rd_val;

    spi_unit_order u_order (
        .ord       (st_q.ord),
        .rx_unit32 (st_q.unit32),
        .rx_line   (rx_next),
        .rx_lo     (rx_lo),
        .rx_hi     (rx_hi),
        .tx_unit32 (st_q.bus_unit32),
        .tx_lo     (tx_lo_in),
        .tx_hi     (rd_val),
        .tx_line   (tx_line)
    );

    // Command word decode
    logic [CMD_W-1:0] cmd;
    logic             c_rd;
    logic [TGT_W-1:0] c_tgt;
    logic [LEN_W-1:0] c_len;
    ord_e             c_ord;
    logic             c_u32;

    assign cmd   = rx_next[CMD_W-1:0];
    assign c_rd  = cmd[CMD_W-1];
    assign c_tgt = cmd[CMD_W-2 -: TGT_W];
    assign c_len = cmd[LEN_W-1:0];
    assign c_ord = ((c_tgt == TGT_CFG) || (cfg_word_mode == ORD_RSVD)) ? ORD_HALF
                                                                        : ord_e'(cfg_word_mode);
    assign c_u32 = (c_ord == ORD_FULL) && (c_len >= LEN_W'(2));

    // Data phase helpers
    logic [LEN_W-1:0]    nw;
    logic [LEN_W-1:0]    left_after;
    logic [BITCNT_W-1:0] unit_last;
    logic                n_u32;

    assign nw         = st_q.unit32 ? LEN_W'(2) : LEN_W'(1);
    assign left_after = st_q.left - nw;
    assign unit_last  = st_q.unit32 ? LAST32 : LAST16;
    assign n_u32      = (st_q.ord == ORD_FULL) && (left_after >= LEN_W'(2));

    always_comb begin
        st_d = st_q;

        if (err_clr) st_d.err = 1'b0;

        // target bus sequencer
        if (st_q.bus_cnt != 2'd0) begin
            st_d.bus_cnt = st_q.bus_cnt - 2'd1;
            if (st_q.bus_rd) begin
                if (st_q.bus_cnt == 2'd2) st_d.word0 = rd_val;
                else                      st_d.tx_sh = tx_line;
            end
        end

        // sample edge
        if (cs_low && sclk_rise) begin
            st_d.rx_sh = rx_next;
            if (st_q.phase == PH_CMD) begin
                if (st_q.bit_cnt == LASTCMD) begin
                    st_d.bit_cnt = '0;
                    st_d.is_rd   = c_rd;
                    st_d.tgt     = c_tgt;
                    st_d.ord     = c_ord;
                    st_d.idx     = '0;
                    st_d.left    = c_len;
                    st_d.unit32  = c_u32;
                    if (c_len != '0) begin
                        st_d.phase = PH_DATA;
                        if (c_rd) begin
                            st_d.bus_cnt    = c_u32 ? 2'd2 : 2'd1;
                            st_d.bus_rd     = 1'b1;
                            st_d.bus_unit32 = c_u32;
                            st_d.bus_idx    = '0;
                        end
                    end
                end else begin
                    st_d.bit_cnt = st_q.bit_cnt + 1'b1;
                end
            end else begin
                if (st_q.bit_cnt == unit_last) begin
                    st_d.bit_cnt = '0;
                    if (!st_q.is_rd) begin
                        st_d.bus_cnt    = st_q.unit32 ? 2'd2 : 2'd1;
                        st_d.bus_rd     = 1'b0;
                        st_d.bus_unit32 = st_q.unit32;
                        st_d.bus_idx    = st_q.idx;
                        st_d.word0      = rx_lo;
                        st_d.word1      = rx_hi;
                    end
                    st_d.left = left_after;
                    st_d.idx  = st_q.idx + nw;
                    if (st_q.left == nw) begin
                        st_d.phase = PH_CMD;
                    end else begin
                        st_d.unit32 = n_u32;
                        if (st_q.is_rd) begin
                            st_d.bus_cnt    = n_u32 ? 2'd2 : 2'd1;
                            st_d.bus_rd     = 1'b1;
                            st_d.bus_unit32 = n_u32;
                            st_d.bus_idx    = st_q.idx + nw;
                        end
                    end
                end else begin
                    st_d.bit_cnt = st_q.bit_cnt + 1'b1;
                end
            end
        end

        // launch edge
        if (cs_low && sclk_fall) begin
            if ((st_q.phase == PH_DATA) && st_q.is_rd) begin
                st_d.miso  = st_q.tx_sh[UNIT_W-1];
                st_d.tx_sh = {st_q.tx_sh[UNIT_W-2:0], 1'b0};
            end else begin
                st_d.miso = 1'b0;
            end
        end

        // chip select release
        if (cs_rise) begin
            st_d.miso = 1'b0;
            if (cfg_frame_en) begin
                if ((st_q.phase == PH_DATA) || (st_q.bit_cnt != '0)) st_d.err = 1'b1;
                st_d.phase   = PH_CMD;
                st_d.bit_cnt = '0;
                st_d.bus_cnt = 2'd0;
                st_d.left    = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_CMD;
            st_q.ord   <= ORD_HALF;
        end else begin
            st_q <= st_d;
        end
    end

    assign spi_miso  = st_q.miso;
    assign err_frame = st_q.err;
    assign tgt_sel   = st_q.tgt;
    assign tgt_wr    = (st_q.bus_cnt != 2'd0) && !st_q.bus_rd && strobe_ok;
    assign tgt_rd    = (st_q.bus_cnt != 2'd0) &&  st_q.bus_rd && strobe_ok;
    assign tgt_wdata = bus_hi ? st_q.word1 : st_q.word0;

    // R2 R3: a word is either written or read, never both
    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(tgt_wr && tgt_rd));

    p_unused_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sel == TGT_NONE) |-> !(tgt_wr || tgt_rd));

    p_data_has_words_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_DATA) |-> (st_q.left != '0));

    p_abort_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && cfg_frame_en && (st_q.phase == PH_DATA)) |=> err_frame);

    p_no_flag_unframed_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_frame && !cfg_frame_en) |=> !err_frame);

    p_err_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (err_frame && !err_clr) |=> err_frame);

    p_miso_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_fall && !cs_rise) |=> $stable(spi_miso));

endmodule

// File: tb/spi_cmd_framer_tb_top.sv
module spi_cmd_framer_tb_top;

    localparam int H = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [1:0]  cfg_word_mode = 2'b00;
    logic        cfg_frame_en = 1'b0;
    logic        err_clr = 1'b0;
    logic        err_frame;
    logic [2:0]  tgt_sel;
    logic        tgt_wr, tgt_rd;
    logic [15:0] tgt_wdata, tgt_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [15:0] rd_mem [64];
    logic [15:0] wr_log [512];
    logic [2:0]  wr_sel [512];
    int          wr_n = 0;
    int          rd_ptr = 0;

    always #5 clk = ~clk;

    spi_cmd_framer dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .spi_sclk      (sclk),
        .spi_cs_n      (cs_n),
        .spi_mosi      (mosi),
        .spi_miso      (miso),
        .cfg_word_mode (cfg_word_mode),
        .cfg_frame_en  (cfg_frame_en),
        .err_clr       (err_clr),
        .err_frame     (err_frame),
        .tgt_sel       (tgt_sel),
        .tgt_wr        (tgt_wr),
        .tgt_rd        (tgt_rd),
        .tgt_wdata     (tgt_wdata),
        .tgt_rdata     (tgt_rdata)
    );

    assign tgt_rdata = rd_mem[rd_ptr[5:0]];

    always @(posedge clk) begin
        if (tgt_wr) begin
            wr_log[wr_n[8:0]] <= tgt_wdata;
            wr_sel[wr_n[8:0]] <= tgt_sel;
            wr_n <= wr_n + 1;
        end
        if (tgt_rd) rd_ptr <= rd_ptr + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send_bits(input logic [31:0] bits, input int n,
                             output logic [31:0] got, output bit unstable);
        got = '0;
        unstable = 1'b0;
        for (int i = 0; i < n; i++) begin
            mosi = bits[n-1-i];
            repeat (H) @(negedge clk);
            got = {got[30:0], miso};
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            if (miso !== got[0]) unstable = 1'b1;
            sclk = 1'b0;
        end
    endtask

    function automatic string tag_of(input bit rd, input logic [2:0] tgt,
                                     input int len, input logic [1:0] mode);
        int eff;
        eff = (tgt == 3'd0 || mode == 2'd3) ? 0 : int'(mode);
        if (rd && tgt == 3'd1 && len > 1) return "R8";
        if (tgt == 3'd7) return "R9";
        if (mode == 2'd3 || (tgt == 3'd0 && mode != 2'd0)) return "R7";
        if (eff == 1) return "R6";
        if (eff == 2) return "R5";
        return "R4";
    endfunction

    task automatic xfer(input bit rd, input logic [2:0] tgt, input int len,
                        input logic [1:0] mode, input bit keep_cs);
        logic [15:0] w [16];
        logic [31:0] got, bits, bad_act, bad_exp;
        int          eff, strobes, wr0, rp0, idx, n;
        bit          bad, unst, u, ok;
        string       tag;
        cfg_word_mode = mode;
        if (cs_n) begin
            cs_n = 1'b0;
            repeat (H) @(negedge clk);
        end
        eff = (tgt == 3'd0 || mode == 2'd3) ? 0 : int'(mode);
        wr0 = wr_n;
        rp0 = rd_ptr;
        strobes = 0;
        for (int k = 0; k < len; k++) begin
            if (rd) begin
                if (tgt == 3'd7 || (tgt == 3'd1 && k > 0)) w[k] = 16'h0;
                else begin
                    w[k] = rd_mem[(rp0 + strobes) % 64];
                    strobes++;
                end
            end else begin
                w[k] = 16'($urandom);
                if (tgt != 3'd7) strobes++;
            end
        end
        send_bits({16'h0, rd, tgt, 12'(len)}, 16, got, u);
        bad = 1'b0; unst = 1'b0; idx = 0;
        bad_act = '0; bad_exp = '0;
        while (idx < len) begin
            if (eff == 1 && len - idx >= 2) begin
                bits = {w[idx+1], w[idx]};
                n = 32;
                idx += 2;
            end else begin
                bits = {16'h0, (eff == 2) ? {w[idx][7:0], w[idx][15:8]} : w[idx]};
                n = 16;
                idx += 1;
            end
            send_bits(bits, n, got, u);
            if (u) unst = 1'b1;
            if (rd && !bad && ((n == 32) ? (got != bits) : (got[15:0] != bits[15:0]))) begin
                bad = 1'b1;
                bad_act = got;
                bad_exp = bits;
            end
        end
        repeat (12) @(negedge clk);
        if (!keep_cs) begin
            cs_n = 1'b1;
            repeat (H) @(negedge clk);
        end
        tag = tag_of(rd, tgt, len, mode);
        if (rd) begin
            chk(!bad, tag, "R3 read word stream on MISO", bad_act, bad_exp);
            chk((rd_ptr - rp0) == strobes, "R3", "read strobe count",
                32'(rd_ptr - rp0), 32'(strobes));
            chk(!unst, "R14", "MISO moved while SCLK high", 32'(unst), 32'd0);
        end else begin
            chk((wr_n - wr0) == strobes, "R2", "write strobe count",
                32'(wr_n - wr0), 32'(strobes));
            ok = 1'b1;
            bad_act = '0; bad_exp = '0;
            for (int k = 0; k < strobes; k++) begin
                if (ok && (wr_log[(wr0 + k) % 512] != w[k] || wr_sel[(wr0 + k) % 512] != tgt)) begin
                    ok = 1'b0;
                    bad_act = {13'h0, wr_sel[(wr0 + k) % 512], wr_log[(wr0 + k) % 512]};
                    bad_exp = {13'h0, tgt, w[k]};
                end
            end
            chk(ok, tag, "R1 written words and target select", bad_act, bad_exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired checks=%0d", checks);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] dummy;
        logic [15:0] w0, w1;
        bit          u;
        int          wr0;
        void'($urandom(32'h5A17));
        for (int i = 0; i < 64; i++) rd_mem[i] = 16'($urandom);

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // reset state
        chk(err_frame === 1'b0, "R13", "error flag after reset", 32'(err_frame), 32'd0);
        chk(miso === 1'b0 && tgt_wr === 1'b0 && tgt_rd === 1'b0, "R2",
            "idle outputs after reset", {29'h0, miso, tgt_wr, tgt_rd}, 32'd0);

        // basic orders and targets
        xfer(1'b0, 3'd2, 1, 2'd0, 1'b0);
        xfer(1'b1, 3'd6, 2, 2'd0, 1'b0);
        xfer(1'b0, 3'd5, 3, 2'd2, 1'b0);
        xfer(1'b1, 3'd4, 2, 2'd2, 1'b0);
        xfer(1'b0, 3'd3, 3, 2'd1, 1'b0);   // R6 pair plus odd word
        xfer(1'b1, 3'd2, 4, 2'd1, 1'b0);   // R6 two pairs
        xfer(1'b0, 3'd0, 2, 2'd2, 1'b0);   // R7 config keeps 16-bit order
        xfer(1'b1, 3'd0, 2, 2'd1, 1'b0);   // R7
        xfer(1'b1, 3'd5, 2, 2'd3, 1'b0);   // R7 reserved order
        xfer(1'b1, 3'd1, 2, 2'd0, 1'b0);   // R8 control upper half zero
        xfer(1'b0, 3'd7, 2, 2'd0, 1'b0);   // R9
        xfer(1'b1, 3'd7, 2, 2'd2, 1'b0);   // R9

        // R10: zero count and back-to-back commands under one chip select
        xfer(1'b0, 3'd2, 1, 2'd0, 1'b1);
        xfer(1'b0, 3'd2, 0, 2'd0, 1'b1);
        xfer(1'b1, 3'd6, 2, 2'd0, 1'b1);
        xfer(1'b0, 3'd4, 1, 2'd0, 1'b0);
        chk(err_frame === 1'b0, "R10", "no flag after chained commands", 32'(err_frame), 32'd0);

        // R11: framing abort mid transfer
        cfg_frame_en = 1'b1;
        cfg_word_mode = 2'b00;
        wr0 = wr_n;
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        w0 = 16'hC3A5;
        send_bits({16'h0, 1'b0, 3'd2, 12'd2}, 16, dummy, u);
        send_bits({16'h0, w0}, 16, dummy, u);
        send_bits(32'h5, 3, dummy, u);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(err_frame === 1'b1, "R11", "flag after early chip select rise", 32'(err_frame), 32'd1);
        chk((wr_n - wr0) == 1 && wr_log[wr0 % 512] == w0, "R11", "only finished word written",
            32'(wr_n - wr0), 32'd1);
        xfer(1'b0, 3'd6, 1, 2'd0, 1'b0);   // R11 resync after abort
        repeat (40) @(negedge clk);
        chk(err_frame === 1'b1, "R13", "flag holds without clear", 32'(err_frame), 32'd1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        @(negedge clk);
        chk(err_frame === 1'b0, "R13", "flag cleared by pulse", 32'(err_frame), 32'd0);

        // R11: abort inside the command word
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        send_bits(32'h2A, 6, dummy, u);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(err_frame === 1'b1, "R11", "flag after partial command", 32'(err_frame), 32'd1);
        xfer(1'b1, 3'd4, 1, 2'd0, 1'b0);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        @(negedge clk);

        // R12: unframed pause
        cfg_frame_en = 1'b0;
        wr0 = wr_n;
        w0 = 16'($urandom);
        w1 = 16'($urandom);
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        send_bits({16'h0, 1'b0, 3'd3, 12'd2}, 16, dummy, u);
        send_bits({24'h0, w0[15:8]}, 8, dummy, u);
        cs_n = 1'b1;
        repeat (20) @(negedge clk);
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        send_bits({8'h0, w0[7:0], w1}, 24, dummy, u);
        repeat (12) @(negedge clk);
        cs_n = 1'b1;
        repeat (H) @(negedge clk);
        chk((wr_n - wr0) == 2 && wr_log[wr0 % 512] == w0 && wr_log[(wr0 + 1) % 512] == w1,
            "R12", "paused transfer resumes", {wr_log[wr0 % 512], wr_log[(wr0 + 1) % 512]}, {w0, w1});
        chk(err_frame === 1'b0, "R12", "no flag without framing", 32'(err_frame), 32'd0);

        // random mix
        for (int t = 0; t < 30; t++) begin
            cfg_frame_en = 1'($urandom);
            xfer(1'($urandom), 3'($urandom), int'($urandom % 7), 2'($urandom), 1'b0);
        end
        chk(err_frame === 1'b0, "R11", "no flag after complete transfers", 32'(err_frame), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule